// File: doc/BRIEF.md
# Transmit Driver Activity Monitor

This block watches a group of transmit channels and flags any channel whose line driver has stopped producing pulses. Each channel has a silence counter clocked by the transmit clock. A pulse-detected strobe from the analog front end resets the counter. When a channel goes too long without a pulse, its live alarm bit rises. The alarm falls again on the next pulse.

Every change of a channel's alarm, rising or falling, is caught in a sticky status bit for that channel. The enabled status bits are combined into one shared active-low interrupt pin. Software finds the event by reading a channel's status, and the read clears that bit. A change that lands in the same cycle as the clearing read is kept, so no event is lost.

Top module: `txdrv_activity_monitor`

## Requirements
- R1: After a synchronous active-low reset, every alarm and status bit reads 0 and `irq_n` is 1.
- R2: A channel's alarm reads 1 once that channel has seen 129 consecutive pulse-free clock edges. After only 128 such edges it still reads 0. The alarm is registered, so it becomes visible just after the 129th edge.
- R3: A clock edge with the channel's pulse strobe high drives its alarm to 0 and restarts its silence count from zero. A pulse on the 129th edge therefore keeps the alarm low.
- R4: The silence count saturates and does not wrap. The alarm stays 1 for any length of silence until a pulse arrives.
- R5: Each rising and each falling transition of a channel's alarm sets that channel's status bit, which stays 1 after the alarm changes again.
- R6: `irq_n` is 0 exactly when at least one channel has both its status bit and its `int_en` bit at 1. A status bit whose enable is 0 does not pull the pin low.
- R7: A cycle with `rd_stb` high clears the status bit of the channel numbered `rd_ch_sel` (binary index, channel 0 = bit 0) and no other channel's bit.
- R8: If an alarm transition and a clearing read of the same channel fall on the same edge, the status bit stays 1.
- R9: Channels are independent: pulses on one channel do not change the alarm or status of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_seen | input | NUM_CH | Per-channel valid-pulse strobe, one bit per channel |
| int_en | input | NUM_CH | Per-channel interrupt enable |
| rd_stb | input | 1 | Status read strobe; clears the selected channel's status |
| rd_ch_sel | input | CH_W | Binary index of the channel being read |
| alarm | output | NUM_CH | Live driver-silence alarm per channel |
| status | output | NUM_CH | Latched alarm-change status per channel |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The silence timer is driven with runs of exactly 128 and 129 pulse-free edges. This separates a correct threshold from an off-by-one. A pulse placed on the 129th edge shows whether a pulse wins over expiry. A 1000-edge silence tells a saturating counter from one that wraps. Some patterns pulse only a subset of channels, or read one channel while others are set; these reveal crosstalk between channels and over-broad clearing. A read timed onto an alarm edge, and alarms raised on channels whose interrupt is disabled, test event retention and interrupt gating.

// File: rtl/txmon_pkg.sv
// Package: shared defaults and helpers for the transmit driver activity monitor.
// Assumes: consumers derive all widths from the parameters given here.
package txmon_pkg;
    localparam int DEF_NUM_CH        = 14;
    localparam int DEF_SILENCE_LIMIT = 128;

    // Per-channel alarm state encoding
    typedef enum logic {
        DRV_ACTIVE = 1'b0,
        DRV_SILENT = 1'b1
    } drv_state_e;

    // Width needed to hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/txmon_silence_timer.sv
// Module: per-channel silence timer.
// Counts pulse-free clock edges and saturates at SILENCE_LIMIT. It raises the
// alarm on the edge that would exceed the limit and drops it on any pulse.
// Assumes: pulse is already synchronous to clk.
module txmon_silence_timer
    import txmon_pkg::*;
#(
    parameter int SILENCE_LIMIT = DEF_SILENCE_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic alarm_o,
    output logic alarm_chg_o
);
    localparam int CNT_W = cnt_width(SILENCE_LIMIT);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SILENCE_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    drv_state_e       state_q, state_d;

    // Next alarm state: a pulse wins, otherwise expiry once the count is full
    always_comb begin
        if (pulse)
            state_d = DRV_ACTIVE;
        else if (cnt_q == CNT_MAX)
            state_d = DRV_SILENT;
        else
            state_d = state_q;
    end

    // Saturating silence counter, restarted by every pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pulse)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    // Alarm state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DRV_ACTIVE;
        else
            state_q <= state_d;
    end

    assign alarm_o     = (state_q == DRV_SILENT);
    assign alarm_chg_o = (state_d != state_q);

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    assert_alarm_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && cnt_q == CNT_MAX) |=> alarm_o);
    assert_pulse_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!alarm_o && cnt_q == '0));
endmodule

// File: rtl/txmon_status_bit.sv
// Module: sticky status bit with clear-on-read.
// A set request wins over a clear request that arrives in the same cycle.
// Assumes: set_i and clr_i are single-cycle requests synchronous to clk.
module txmon_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic status_o
);
    logic status_q;

    // Hold the status; set has priority so that an event is never dropped
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (set_i)
            status_q <= 1'b1;
        else if (clr_i)
            status_q <= 1'b0;
    end

    assign status_o = status_q;

    assert_set_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> status_o);
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !status_o);
endmodule

// File: rtl/txmon_irq_combine.sv
// Module: combines the enabled status bits into the active-low interrupt.
// Assumes: its inputs come straight from registers, so the output has no
// hazard from multi-level logic.
module txmon_irq_combine #(
    parameter int NUM_CH = 14
) (
    input  logic [NUM_CH-1:0] status_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic              irq_n_o
);
    logic [NUM_CH-1:0] pending;

    // Per-channel gating followed by the OR reduction
    always_comb begin
        pending = status_i & en_i;
        irq_n_o = ~(|pending);
    end
endmodule

// File: rtl/txdrv_activity_monitor.sv
// Module: transmit driver activity monitor (top).
// Holds one silence timer and one status bit per channel, a read decoder and
// the shared interrupt. A read clears the status of the selected channel.
// Assumes: every input is synchronous to clk; rd_ch_sel values at or above
// NUM_CH select no channel.
module txdrv_activity_monitor
    import txmon_pkg::*;
#(
    parameter int NUM_CH        = DEF_NUM_CH,
    parameter int SILENCE_LIMIT = DEF_SILENCE_LIMIT,
    localparam int CH_W         = (NUM_CH < 2) ? 1 : $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pulse_seen,
    input  logic [NUM_CH-1:0] int_en,
    input  logic              rd_stb,
    input  logic [CH_W-1:0]   rd_ch_sel,
    output logic [NUM_CH-1:0] alarm,
    output logic [NUM_CH-1:0] status,
    output logic              irq_n
);
    logic [NUM_CH-1:0] alarm_chg;
    logic [NUM_CH-1:0] rd_hit;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Decode a read aimed at this channel
        always_comb rd_hit[ch] = rd_stb && (rd_ch_sel == CH_W'(ch));

        txmon_silence_timer #(
            .SILENCE_LIMIT(SILENCE_LIMIT)
        ) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .pulse      (pulse_seen[ch]),
            .alarm_o    (alarm[ch]),
            .alarm_chg_o(alarm_chg[ch])
        );

        txmon_status_bit u_status (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (alarm_chg[ch]),
            .clr_i   (rd_hit[ch]),
            .status_o(status[ch])
        );

        assert_change_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm[ch] != $past(alarm[ch])) |-> status[ch]);
    end

    txmon_irq_combine #(
        .NUM_CH(NUM_CH)
    ) u_irq (
        .status_i(status),
        .en_i    (int_en),
        .irq_n_o (irq_n)
    );

    assert_idle_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> irq_n);
    assert_read_one_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && alarm_chg == '0) |=> ($countones($past(status) & ~status) <= 1));
endmodule

// File: tb/txdrv_activity_monitor_tb.sv
// Bench: directed tests, one task per scenario, for txdrv_activity_monitor.
module txdrv_activity_monitor_tb;
    localparam int NCH  = 14;
    localparam int LIM  = 128;
    localparam int CHW  = $clog2(NCH);
    localparam logic [NCH-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] pulse_seen = '0;
    logic [NCH-1:0] int_en = '0;
    logic rd_stb = 1'b0;
    logic [CHW-1:0] rd_ch_sel = '0;
    logic [NCH-1:0] alarm, status;
    logic irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    txdrv_activity_monitor #(.NUM_CH(NCH), .SILENCE_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_seen(pulse_seen), .int_en(int_en),
        .rd_stb(rd_stb), .rd_ch_sel(rd_ch_sel),
        .alarm(alarm), .status(status), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock edge; inputs set before, outputs sampled after at the negedge
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_all();
        pulse_seen = ALL; step(1); pulse_seen = '0;
    endtask

    task automatic read_ch(input int ch);
        rd_stb = 1'b1; rd_ch_sel = CHW'(ch); step(1); rd_stb = 1'b0;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NCH; c++) read_ch(c);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(3); rst_n = 1'b1;
        chk("R1 alarm", 32'(alarm), 0);
        chk("R1 status", 32'(status), 0);
        chk("R1 irq_n", 32'(irq_n), 1);
    endtask

    task automatic t_threshold();
        pulse_all(); clear_all();
        pulse_all();
        step(LIM);
        chk("R2 128 silent", 32'(alarm), 0);
        step(1);
        chk("R2 129 silent", 32'(alarm), 32'(ALL));
        chk("R5 rise latched", 32'(status), 32'(ALL));
    endtask

    task automatic t_saturate();
        step(1000);
        chk("R4 long silence", 32'(alarm), 32'(ALL));
        clear_all();
        chk("R7 all cleared", 32'(status), 0);
        pulse_all();
        chk("R3 pulse clears", 32'(alarm), 0);
        chk("R5 fall latched", 32'(status), 32'(ALL));
    endtask

    task automatic t_pulse_at_edge();
        pulse_all(); clear_all(); pulse_all();
        step(LIM);
        pulse_all();
        chk("R3 pulse on 129th", 32'(alarm), 0);
        step(LIM);
        chk("R3 count restarted", 32'(alarm), 0);
        chk("R3 no status", 32'(status), 0);
        step(1);
        chk("R3 expiry after restart", 32'(alarm), 32'(ALL));
    endtask

    task automatic t_irq_gate();
        pulse_all(); clear_all(); pulse_all();
        int_en = '0;
        step(LIM + 1);
        chk("R6 disabled no irq", 32'(irq_n), 1);
        int_en = NCH'(1) << 5;
        step(1);
        chk("R6 enabled irq", 32'(irq_n), 0);
        read_ch(5);
        chk("R6 irq released", 32'(irq_n), 1);
        chk("R7 only ch5 cleared", 32'(status), 32'(ALL & ~(NCH'(1) << 5)));
        int_en = '0;
    endtask

    task automatic t_read_collision();
        pulse_all(); clear_all(); pulse_all();
        step(LIM);
        rd_stb = 1'b1; rd_ch_sel = CHW'(0);
        step(1);
        rd_stb = 1'b0;
        chk("R8 set wins", 32'(status[0]), 1);
        chk("R8 alarm up", 32'(alarm[0]), 1);
    endtask

    task automatic t_independent();
        logic [NCH-1:0] keep;
        keep = NCH'(1) << 3;
        pulse_all(); clear_all(); pulse_all();
        for (int k = 0; k < 3; k++) begin
            step(49);
            pulse_seen = keep; step(1); pulse_seen = '0;
        end
        chk("R9 others alarmed", 32'(alarm), 32'(ALL & ~keep));
        chk("R9 ch3 status clean", 32'(status[3]), 0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_saturate();
        t_pulse_at_edge();
        t_irq_gate();
        t_read_collision();
        t_independent();
        t_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule